// File: doc/BRIEF.md
# Grouped Lookahead Column Hit Scanner

This block watches the hit flags of one detector column of 200 pixel cells and tells the end-of-column logic which pending pixel to serve next. Each hit that arrives on `hit_in` is stored in a pending register. The lowest-numbered pending row is offered on `row`, together with a one-hot `sel` and a `valid` flag. Row 0 has the highest priority. The end-of-column logic takes the offered row and pulses `ack` for one cycle. That pulse clears the served pixel, and the next pending row is offered in the cycle after.

A plain ripple chain would pass the grant token through every cell. This scan works in two levels instead. The cells are split into groups of 8, which gives 25 groups. Each group forms an any-hit term and picks its own first cell. A lookahead enable then runs across the groups only. The first group that holds a hit blocks every group after it, so the delay of the chain grows with the number of groups and not with the number of cells.

The control is a two-state machine:
- `ST_EMPTY`: nothing is pending.
- `ST_SERVE`: at least one row is pending and is being offered.

It has two transitions:
- `ARRIVE`: from `ST_EMPTY` to `ST_SERVE`, taken when any `hit_in` bit is set.
- `DRAIN`: from `ST_SERVE` back to `ST_EMPTY`, taken when an `ack` clears the last pending row and no new hit arrives in that cycle.

In every other case the state holds.

Top module: `col_hit_scan`

## Requirements
- R1: While `rst_n` is low and after it is released, before any hit arrives, `valid` is 0, `row` is 0 and `sel` is all zero.
- R2: A `hit_in` bit i that is high at a rising clock edge becomes pending at that edge. From that edge on, the outputs account for it.
- R3: `valid` is 1 exactly when at least one row is pending.
- R4: While `valid` is 1, `row` gives the lowest pending row index as an unsigned binary number from 0 to 199. Row 0 has the highest priority. While `valid` is 0, `row` is 0.
- R5: `sel` has at most one bit set. While `valid` is 1, the set bit is bit `row`. While `valid` is 0, `sel` is all zero.
- R6: When `ack` is high at an edge while `valid` is 1, the offered row stops being pending at that edge. After that edge, the next-priority pending row is offered.
- R7: When `ack` is high at an edge while `valid` is 0, it has no effect.
- R8: When `ack` clears a row and `hit_in` carries that same row in the same cycle, the row stays pending.
- R9: An `ack` clears only the offered row. All other pending rows stay pending until each of them is served in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_in | input | 200 | New hit flags, one per row, bit i is row i |
| ack | input | 1 | One-cycle pulse that marks the offered row as served |
| valid | output | 1 | A pending row is being offered |
| row | output | 8 | Address of the offered row |
| sel | output | 200 | One-hot select of the offered row |

## Verification
The bench drives these patterns:
- A column with no hits. This catches a scanner that reports a phantom row.
- A full column drained with 200 acks. A broken group lookahead would skip rows or offer two of them at once.
- A single hit on row 199, the last cell of the last group. A chain that drops its final group would never report it.
- Hits that straddle group boundaries, such as rows 7 and 8. These expose a priority that prefers a later group.

Three corner cases around the acknowledge are also run:
- An ack on an empty column, which must leave the column empty.
- An ack that coincides with a new hit on the served row, which must not lose the hit.
- Random sparse and dense patterns, drained by acks with new hits mixed in, so that stale or wrongly cleared pending bits show up.

// File: rtl/col_scan_pkg.sv
package col_scan_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_SERVE = 1'b1
    } scan_state_e;
endpackage

// File: rtl/scan_group.sv
// One group of cells: any-hit summary plus local priority pick.
module scan_group #(
    parameter int GRP = 8,
    localparam int LW = $clog2(GRP)
) (
    input  logic [GRP-1:0] hits,
    output logic           any_hit,
    output logic [GRP-1:0] local_sel,
    output logic [LW-1:0]  local_idx
);
    always_comb begin
        logic seen;
        seen      = 1'b0;
        local_sel = '0;
        local_idx = '0;
        for (int i = 0; i < GRP; i++) begin
            local_sel[i] = hits[i] & ~seen;
            if (hits[i] && !seen) local_idx = LW'(i);
            seen = seen | hits[i];
        end
        any_hit = seen;
    end
endmodule

// File: rtl/group_chain.sv
// Lookahead enable that runs across groups; a hit group blocks all later ones.
module group_chain #(
    parameter int NG = 25
) (
    input  logic [NG-1:0] grp_any,
    output logic [NG-1:0] grp_win
);
    logic [NG:0] fast;

    assign fast[0] = 1'b1;

    for (genvar g = 0; g < NG; g++) begin : g_link
        assign fast[g+1]  = fast[g] & ~grp_any[g];
        assign grp_win[g] = fast[g] & grp_any[g];
    end
endmodule

// File: rtl/col_hit_scan.sv
module col_hit_scan #(
    parameter int N_CELLS = 200,
    parameter int GRP     = 8,
    localparam int NG     = N_CELLS / GRP,
    localparam int AW     = $clog2(N_CELLS),
    localparam int LW     = $clog2(GRP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] hit_in,
    input  logic               ack,
    output logic               valid,
    output logic [AW-1:0]      row,
    output logic [N_CELLS-1:0] sel
);
    import col_scan_pkg::*;

    scan_state_e           state_q, state_n;
    logic [N_CELLS-1:0]    pend_q, pend_n;
    logic [NG-1:0]         grp_any, grp_win;
    logic [NG-1:0][GRP-1:0] loc_sel;
    logic [NG-1:0][LW-1:0]  loc_idx;
    logic [N_CELLS-1:0]    sel_c;
    logic [AW-1:0]         row_c;
    logic [N_CELLS-1:0]    clr;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        scan_group #(.GRP(GRP)) u_grp (
            .hits      (pend_q[g*GRP +: GRP]),
            .any_hit   (grp_any[g]),
            .local_sel (loc_sel[g]),
            .local_idx (loc_idx[g])
        );
        assign sel_c[g*GRP +: GRP] = loc_sel[g] & {GRP{grp_win[g]}};
    end

    group_chain #(.NG(NG)) u_chain (
        .grp_any (grp_any),
        .grp_win (grp_win)
    );

    always_comb begin
        row_c = '0;
        for (int g = 0; g < NG; g++) begin
            if (grp_win[g]) row_c = AW'(g * GRP) + AW'(loc_idx[g]);
        end
    end

    // Served cell is cleared first, then fresh hits are merged in.
    always_comb begin
        clr    = (ack && state_q == ST_SERVE) ? sel_c : '0;
        pend_n = (pend_q & ~clr) | hit_in;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_EMPTY: if (|hit_in)     state_n = ST_SERVE;
            ST_SERVE: if (pend_n == '0) state_n = ST_EMPTY;
            default:                   state_n = ST_EMPTY;
        endcase
    end

    // State register and pending store.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            pend_q  <= '0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
        end
    end

    // Outputs.
    always_comb begin
        valid = (state_q == ST_SERVE);
        row   = valid ? row_c : '0;
        sel   = valid ? sel_c : '0;
    end
endmodule

// File: rtl/col_hit_scan_chk.sv
module col_hit_scan_chk #(
    parameter int N_CELLS = 200,
    parameter int AW      = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CELLS-1:0] hit_in,
    input logic               ack,
    input logic               valid,
    input logic [AW-1:0]      row,
    input logic [N_CELLS-1:0] sel
);
    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    p_sel_at_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((sel >> row) & N_CELLS'(1)) == N_CELLS'(1));

    p_idle_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (sel == '0 && row == '0));

    p_hit_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_in != '0) |=> valid);

    p_empty_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && hit_in == '0) |=> !valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && hit_in == '0) |=> ($stable(valid) && $stable(row)));

    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ack && hit_in == '0) |=> (!valid || row > $past(row)));
endmodule

bind col_hit_scan col_hit_scan_chk #(.N_CELLS(N_CELLS), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_in (hit_in),
    .ack    (ack),
    .valid  (valid),
    .row    (row),
    .sel    (sel)
);

// File: tb/col_hit_scan_bench.sv
module col_hit_scan_bench;
    localparam int N  = 200;
    localparam int AW = 8;

    typedef struct {
        logic          v;
        logic [AW-1:0] r;
        logic [N-1:0]  s;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hit_in = '0;
    logic          ack = 1'b0;
    logic          valid;
    logic [AW-1:0] row;
    logic [N-1:0]  sel;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;
    exp_t sb[$];
    logic [N-1:0] ref_pend = '0;

    always #2.5 clk = ~clk;

    col_hit_scan u_col_hit_scan (
        .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .ack(ack),
        .valid(valid), .row(row), .sel(sel)
    );

    function automatic int first_set(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic [N-1:0] h, input logic a, input string tag);
        exp_t e;
        int   p;
        @(negedge clk);
        hit_in = h;
        ack    = a;
        p = first_set(ref_pend);
        if (a && p >= 0) ref_pend[p] = 1'b0;
        ref_pend = ref_pend | h;
        p = first_set(ref_pend);
        e.v   = (p >= 0);
        e.r   = (p >= 0) ? AW'(p) : '0;
        e.s   = (p >= 0) ? (N'(1) << p) : '0;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain(input string tag);
        while (ref_pend != '0) step('0, 1'b1, tag);
        step('0, 1'b0, tag);
    endtask

    function automatic logic [N-1:0] rand_vec(input int density);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (($urandom % 100) < density);
        return v;
    endfunction

    // Monitor: one time unit after each edge, compare with the queue head.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (valid !== e.v || row !== e.r) begin
                n_fail++;
                $display("FAIL %s: valid=%0b row=%0d expected valid=%0b row=%0d",
                         e.tag, valid, row, e.v, e.r);
            end
            n_checks++;
            if (sel !== e.s) begin
                n_fail++;
                $display("FAIL R5 (%s): sel=%h expected=%h", e.tag, sel, e.s);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        n_checks++;
        if (valid !== 1'b0 || row !== '0 || sel !== '0) begin
            n_fail++;
            $display("FAIL R1: valid=%0b row=%0d expected valid=0 row=0 sel=0", valid, row);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step('0, 1'b0, "R1");
        step('0, 1'b0, "R3");

        // Ack on an empty column.
        step('0, 1'b1, "R7");
        step('0, 1'b0, "R7");

        // Only the last row.
        v = '0; v[199] = 1'b1;
        step(v, 1'b0, "R2");
        step('0, 1'b0, "R4");
        drain("R6");

        // Group boundary rows 7 and 8, plus a far row.
        v = '0; v[8] = 1'b1; v[7] = 1'b1; v[150] = 1'b1;
        step(v, 1'b0, "R4");
        drain("R9");

        // Ack with a fresh hit on the same row.
        v = '0; v[5] = 1'b1; v[40] = 1'b1;
        step(v, 1'b0, "R2");
        v = '0; v[5] = 1'b1;
        step(v, 1'b1, "R8");
        step('0, 1'b0, "R8");
        drain("R6");

        // Full column drained one row at a time.
        step('1, 1'b0, "R4");
        drain("R9");

        // Random patterns with mixed new hits during the drain.
        for (int k = 0; k < 40; k++) begin
            step(rand_vec((k % 2 == 0) ? 3 : 40), 1'b0, "R4");
            for (int j = 0; j < 6; j++)
                step(rand_vec(1), ($urandom % 2) == 1, "R9");
            drain("R6");
        end

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule